// File: doc/BRIEF.md
# Credit-Based Burst Flow Controller

This block sits on the bus-master side of a multi-channel transfer engine. It decides when each channel may start a burst to or from a remote peripheral FIFO. The peripheral sends no level, threshold or request line. It sends only one pulse per word that it moves through its FIFO on the far side. For every channel the controller therefore keeps its own occupancy count. It compares that count against a programmed copy of the remote FIFO depth and a programmed burst length.

A playback channel sends data towards the peripheral. Each accepted write burst adds the burst length to the count, and each pulse (a word popped remotely) removes one. A write burst is allowed while the free space, size minus count, is at least one burst. A capture channel receives data from the peripheral. Each pulse (a word pushed remotely) adds one, and each accepted read burst removes the burst length. A read burst is allowed once at least one burst of words is waiting. The programmed size must equal the true remote depth. If it is larger, the controller over-sends, and a sticky overrun flag reports any count that would pass the programmed size. If it is smaller, transfers stall while room still exists.

The request leaves on a valid/ready pair. The controller holds at most one request at a time. A round-robin arbiter picks the channel whenever no request is held. Once `req_valid` is high, `req_chan`, `req_len` and `req_dir` stay fixed until `req_ready` is seen high on a clock edge. That edge commits the burst to the count. The single exception is when the requested channel is disabled or soft-reset; the request is then withdrawn. A new request can appear no earlier than one idle cycle after a handshake.

Top module: `credit_burst_flow`

## Requirements
- R1: After reset `req_valid` is 0, every occupancy count is 0 and every `overrun` bit is 0.
- R2: A playback channel (`cfg_dir`=0) becomes eligible when size minus count is at least its burst length. An accepted burst raises its count by the burst length, and each word pulse lowers it by one.
- R3: A capture channel (`cfg_dir`=1) becomes eligible when its count is at least its burst length. Each word pulse raises its count by one, and an accepted burst lowers it by the burst length.
- R4: While `req_valid` is 1 and `req_ready` is 0, the request and its fields stay unchanged. A handshake (both 1 at a clock edge) commits the burst and drops `req_valid` for at least one cycle.
- R5: When several channels are eligible, the grant rotates. The channel chosen is the first eligible one in increasing index order, wrapping around, after the channel granted last.
- R6: A word pulse in the same cycle as the handshake of that channel is applied together with the commit, so no count is lost.
- R7: `overrun[i]` is set when channel i's count would exceed its programmed size. The count is then held at the size, and the flag stays set until the channel is disabled or soft-reset.
- R8: A playback pop pulse while the count is 0 is ignored and the count stays 0.
- R9: `cfg_en[i]`=0 or `soft_rst[i]`=1 clears channel i's count and overrun flag and withdraws a request held for channel i.
- R10: `cfg_err[i]` is 1 when channel i's burst length is 0 or larger than its FIFO size. Such a channel is never requested.
- R11: `req_len` equals the requested channel's burst length and `req_dir` its direction (0 write/playback, 1 read/capture), both captured at the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | NCH | Per-channel enable; low clears the channel |
| cfg_dir | input | NCH | Per-channel direction, 0 playback, 1 capture |
| cfg_fifo_size | input | NCH*CW | Per-channel remote FIFO depth in words, channel i at bits i*CW |
| cfg_burst | input | NCH*CW | Per-channel burst length in words, channel i at bits i*CW |
| soft_rst | input | NCH | Per-channel synchronous clear |
| word_pulse | input | NCH | One pulse per word moved through the remote FIFO |
| req_valid | output | 1 | Burst request pending |
| req_ready | input | 1 | Downstream accepts the request; commits the burst |
| req_chan | output | $clog2(NCH) | Requested channel index |
| req_len | output | CW | Burst length of the request |
| req_dir | output | 1 | Direction of the request |
| overrun | output | NCH | Sticky per-channel overrun flag |
| cfg_err | output | NCH | Per-channel configuration error |

## Verification
A playback channel is filled to its size with ready held high and then drained pulse by pulse. This shows whether the free-space rule and the unit decrement are both exact. A capture channel has a pulse land in the very cycle of its handshake, and the next request appears only once the combined count is reached, which tells a merged update from a dropped pulse. Pops sent to an empty playback channel, and pushes past a capture channel's size, separate clamping from wrap-around. Three channels that are all eligible at once, granted right after a fourth, reveal the rotation order through the scoreboard's sequence of expected grants.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  typedef enum logic {
    DIR_PLAY = 1'b0,
    DIR_CAP  = 1'b1
  } dir_e;
endpackage

// File: rtl/cbf_track.sv
module cbf_track
  import cbf_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          soft_rst,
  input  dir_e          dir,
  input  logic [CW-1:0] fifo_sz,
  input  logic [CW-1:0] burst,
  input  logic          pulse,
  input  logic          commit,
  output logic          eligible,
  output logic          cfg_err,
  output logic          overrun
);
  localparam int SW = CW + 2;

  logic [CW-1:0]        occ, occ_d;
  logic                 ovr_q, ovr_set;
  logic [CW-1:0]        up, dn;
  logic signed [SW-1:0] nxt;

  // playback: commit fills, pulse drains; capture: the reverse
  always_comb begin
    if (dir == DIR_PLAY) begin
      up = commit ? burst : '0;
      dn = {{(CW-1){1'b0}}, pulse};
    end else begin
      up = {{(CW-1){1'b0}}, pulse};
      dn = commit ? burst : '0;
    end
    nxt = $signed({2'b00, occ}) + $signed({2'b00, up}) - $signed({2'b00, dn});
    ovr_set = 1'b0;
    if (nxt < 0) begin
      occ_d = '0;
    end else if (nxt > $signed({2'b00, fifo_sz})) begin
      occ_d   = fifo_sz;
      ovr_set = 1'b1;
    end else begin
      occ_d = nxt[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ   <= '0;
      ovr_q <= 1'b0;
    end else if (!en || soft_rst) begin
      occ   <= '0;
      ovr_q <= 1'b0;
    end else begin
      occ   <= occ_d;
      ovr_q <= ovr_q | ovr_set;
    end
  end

  assign cfg_err = (burst == '0) || (burst > fifo_sz);
  assign overrun = ovr_q;

  always_comb begin
    eligible = en && !soft_rst && !cfg_err;
    if (dir == DIR_PLAY)
      eligible = eligible && (({1'b0, occ} + {1'b0, burst}) <= {1'b0, fifo_sz});
    else
      eligible = eligible && (occ >= burst);
  end
endmodule

// File: rtl/cbf_rr_arb.sv
module cbf_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 take,
  output logic                 any,
  output logic [$clog2(N)-1:0] gnt
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last;

  // first requester after the last grant, wrapping
  always_comb begin
    int idx;
    any = 1'b0;
    gnt = '0;
    for (int off = 1; off <= N; off++) begin
      idx = (int'(last) + off) % N;
      if (!any && req[idx]) begin
        any = 1'b1;
        gnt = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= IW'(N - 1);
    else if (take && any) last <= gnt;
  end
endmodule

// File: rtl/credit_burst_flow.sv
module credit_burst_flow
  import cbf_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          cfg_en,
  input  logic [NCH-1:0]          cfg_dir,
  input  logic [NCH*CW-1:0]       cfg_fifo_size,
  input  logic [NCH*CW-1:0]       cfg_burst,
  input  logic [NCH-1:0]          soft_rst,
  input  logic [NCH-1:0]          word_pulse,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [$clog2(NCH)-1:0]  req_chan,
  output logic [CW-1:0]           req_len,
  output logic                    req_dir,
  output logic [NCH-1:0]          overrun,
  output logic [NCH-1:0]          cfg_err
);
  localparam int IW = $clog2(NCH);

  logic [NCH-1:0] elig, commit, kill;
  logic           any;
  logic [IW-1:0]  gnt;
  logic           grant;

  assign grant = !req_valid && any;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign commit[i] = req_valid && req_ready && (req_chan == IW'(i));
    assign kill[i]   = !cfg_en[i] || soft_rst[i];

    cbf_track #(.CW(CW)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_en[i]),
      .soft_rst (soft_rst[i]),
      .dir      (dir_e'(cfg_dir[i])),
      .fifo_sz  (cfg_fifo_size[i*CW +: CW]),
      .burst    (cfg_burst[i*CW +: CW]),
      .pulse    (word_pulse[i]),
      .commit   (commit[i]),
      .eligible (elig[i]),
      .cfg_err  (cfg_err[i]),
      .overrun  (overrun[i])
    );
  end

  cbf_rr_arb #(.N(NCH)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (elig),
    .take  (grant),
    .any   (any),
    .gnt   (gnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_chan  <= '0;
      req_len   <= '0;
      req_dir   <= 1'b0;
    end else if (req_valid) begin
      if (req_ready || kill[req_chan]) req_valid <= 1'b0;
    end else if (any) begin
      req_valid <= 1'b1;
      req_chan  <= gnt;
      req_len   <= cfg_burst[gnt*CW +: CW];
      req_dir   <= cfg_dir[gnt];
    end
  end
endmodule

// File: rtl/cbf_chk.sv
module cbf_chk #(
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [$clog2(NCH)-1:0] req_chan,
  input logic [CW-1:0]          req_len,
  input logic                   req_dir,
  input logic [NCH-1:0]         cfg_en,
  input logic [NCH-1:0]         soft_rst,
  input logic [NCH-1:0]         overrun,
  input logic [NCH-1:0]         cfg_err,
  input logic [NCH*CW-1:0]      cfg_burst
);
  logic [NCH-1:0]    err_q;
  logic [NCH*CW-1:0] burst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= '0;
      burst_q <= '0;
    end else begin
      err_q   <= cfg_err;
      burst_q <= cfg_burst;
    end
  end

  // R4
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && cfg_en[req_chan] && !soft_rst[req_chan]
    |=> req_valid && $stable(req_chan) && $stable(req_len) && $stable(req_dir));

  // R4
  gap_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);

  // R9
  withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (!cfg_en[req_chan] || soft_rst[req_chan]) |=> !req_valid);

  // R10
  no_bad_cfg_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> !err_q[req_chan]);

  // R11
  len_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> req_len == burst_q[req_chan*CW +: CW]);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R7
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun[i] && cfg_en[i] && !soft_rst[i] |=> overrun[i]);

    // R9
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en[i] || soft_rst[i] |=> !overrun[i]);
  end
endmodule

bind credit_burst_flow cbf_chk #(.NCH(NCH), .CW(CW)) u_chk (.*);

// File: tb/sim_credit_burst_flow.sv
`timescale 1ns/1ps
module sim_credit_burst_flow;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int IW  = $clog2(NCH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    cfg_en = '0;
  logic [NCH-1:0]    cfg_dir = '0;
  logic [NCH*CW-1:0] cfg_fifo_size = '0;
  logic [NCH*CW-1:0] cfg_burst = '0;
  logic [NCH-1:0]    soft_rst = '0;
  logic [NCH-1:0]    word_pulse = '0;
  logic              req_valid;
  logic              req_ready = 1'b0;
  logic [IW-1:0]     req_chan;
  logic [CW-1:0]     req_len;
  logic              req_dir;
  logic [NCH-1:0]    overrun;
  logic [NCH-1:0]    cfg_err;

  credit_burst_flow #(.NCH(NCH), .CW(CW)) u0 (.*);

  always #2 clk = ~clk;

  typedef struct {
    int    c;
    int    d;
    int    l;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setch(input int c, input bit en, input bit dir, input int fs, input int bs);
    cfg_en[c]                = en;
    cfg_dir[c]               = dir;
    cfg_fifo_size[c*CW +: CW] = CW'(fs);
    cfg_burst[c*CW +: CW]     = CW'(bs);
  endtask

  task automatic pulses(input int c, input int n);
    word_pulse[c] = 1'b1;
    repeat (n) tick();
    word_pulse[c] = 1'b0;
  endtask

  task automatic expect_item(input int c, input int d, input int l, input string tag);
    item_t it;
    it.c = c; it.d = d; it.l = l; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle_check(input string tag, input int n);
    repeat (n) tick();
    @(negedge clk);
    check(req_valid == 1'b0, tag, int'(req_valid), 0);
    check(q.size() == 0, {tag, " pending grants"}, q.size(), 0);
  endtask

  // monitor: scoreboard compare on every handshake
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R4 unexpected grant chan", int'(req_chan), -1);
      end else begin
        item_t it;
        it = q.pop_front();
        check(int'(req_chan) == it.c, {it.tag, " chan"}, int'(req_chan), it.c);
        check(int'(req_dir) == it.d, "R11 dir", int'(req_dir), it.d);
        check(int'(req_len) == it.l, "R11 len", int'(req_len), it.l);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [IW-1:0] hc;
    logic [CW-1:0] hl;
    logic          hd;
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(req_valid == 1'b0, "R1 req_valid", int'(req_valid), 0);
    check(overrun == '0, "R1 overrun", int'(overrun), 0);

    // R2 playback fill and drain, ch0 size 8 burst 4
    req_ready = 1'b1;
    expect_item(0, 0, 4, "R2 fill");
    expect_item(0, 0, 4, "R2 fill");
    tick();
    setch(0, 1, 0, 8, 4);
    idle_check("R2 full stops", 12);
    pulses(0, 3);
    idle_check("R2 free 3 below burst", 6);
    expect_item(0, 0, 4, "R2 refill");
    pulses(0, 1);
    idle_check("R2 after refill", 8);

    // R3 capture ch1 size 8 burst 3
    tick();
    setch(0, 0, 0, 8, 4);
    setch(1, 1, 1, 8, 3);
    req_ready = 1'b0;
    pulses(1, 2);
    idle_check("R3 two words short", 5);
    pulses(1, 1);
    repeat (3) tick();
    @(negedge clk);
    check(req_valid == 1'b1, "R3 request", int'(req_valid), 1);
    check(int'(req_chan) == 1, "R3 chan", int'(req_chan), 1);
    hc = req_chan; hl = req_len; hd = req_dir;
    repeat (3) begin
      tick();
      @(negedge clk);
      check(req_valid && req_chan == hc && req_len == hl && req_dir == hd,
            "R4 held fields", int'(req_valid), 1);
    end
    // R6 pulse in the handshake cycle: 3 + 1 - 3 = 1
    expect_item(1, 1, 3, "R6 commit");
    tick();
    req_ready = 1'b1;
    word_pulse[1] = 1'b1;
    tick();
    req_ready = 1'b0;
    word_pulse[1] = 1'b0;
    pulses(1, 1);
    idle_check("R6 count two", 5);
    pulses(1, 1);
    repeat (3) tick();
    @(negedge clk);
    check(req_valid == 1'b1 && int'(req_chan) == 1, "R6 third word", int'(req_valid), 1);
    expect_item(1, 1, 3, "R6 next");
    tick();
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0;
    idle_check("R6 drained", 4);

    // R7 capture ch2 size 4 burst 4, push past size
    setch(1, 0, 1, 8, 3);
    setch(2, 1, 1, 4, 4);
    pulses(2, 4);
    @(negedge clk);
    check(overrun == '0, "R7 no overrun at size", int'(overrun), 0);
    tick();
    pulses(2, 1);
    @(negedge clk);
    check(overrun == 4'b0100, "R7 overrun set", int'(overrun), 4);
    repeat (3) tick();
    @(negedge clk);
    check(overrun == 4'b0100, "R7 overrun sticky", int'(overrun), 4);
    check(req_valid == 1'b1 && int'(req_chan) == 2, "R7 pending", int'(req_valid), 1);
    // R9 soft reset clears and withdraws
    tick();
    soft_rst[2] = 1'b1;
    tick();
    soft_rst[2] = 1'b0;
    @(negedge clk);
    check(req_valid == 1'b0, "R9 withdrawn", int'(req_valid), 0);
    check(overrun == '0, "R9 overrun cleared", int'(overrun), 0);
    tick();
    pulses(2, 3);
    idle_check("R9 count cleared", 5);
    req_ready = 1'b1;
    expect_item(2, 1, 4, "R9 recount");
    pulses(2, 1);
    idle_check("R9 after recount", 6);

    // R8 pops at empty playback ch3 size 4 burst 2
    req_ready = 1'b0;
    setch(2, 0, 1, 4, 4);
    setch(3, 1, 0, 4, 2);
    repeat (3) tick();
    pulses(3, 3);
    expect_item(3, 0, 2, "R8 first");
    expect_item(3, 0, 2, "R8 second");
    req_ready = 1'b1;
    idle_check("R8 pops ignored", 12);

    // R5 rotation among ch0..2 after ch3 granted last
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 3; c++) expect_item(c, 0, 2, "R5 rotation");
    end
    setch(3, 0, 0, 4, 2);
    for (int c = 0; c < 3; c++) setch(c, 1, 0, 8, 2);
    idle_check("R5 all full", 40);

    // R10 bad configurations
    for (int c = 0; c < NCH; c++) setch(c, 0, 0, 8, 2);
    tick();
    setch(0, 1, 0, 8, 0);
    setch(1, 1, 0, 8, 9);
    setch(2, 1, 1, 8, 8);
    tick();
    @(negedge clk);
    check(cfg_err == 4'b0011, "R10 cfg_err", int'(cfg_err), 3);
    idle_check("R10 never requested", 20);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule